// File: doc/BRIEF.md
# Modified/Invalid Home Directory with DMA Access

This block is the home node for a two-state (Modified/Invalid) coherence scheme over a small range of blocks. For every block it remembers which core, if any, holds the only valid copy. It accepts exclusive-get requests and writebacks from cores and read/write requests from a DMA engine. It drives a single-outstanding memory port and emits one coherence message per cycle: forwards, data, acknowledgements, negative acknowledgements, invalidations and DMA completions.

Incoming requests wait in a small queue. Each cycle the oldest queued request whose block can make progress is served. A request whose block is in a transient state stays queued and is not dropped. The one exception is the writeback that a DMA invalidation is waiting for: it may pass older stalled requests to the same block. Ownership moves to a new requester as soon as a forward is sent. A writeback that arrives after ownership has already moved is refused.

Top module: `mi_dir_ctrl`

## Requirements
- R1: After reset every block is unowned, `out_valid` and `mem_req_valid` are low and `req_ready` is high.
- R2: An exclusive get (`req_kind` 0) to an unowned block issues one memory read of that block. The memory data is then sent to the requester as a data message (`out_kind` 1), and the requester becomes the owner.
- R3: An exclusive get to an owned block sends a forward (`out_kind` 0) to the current owner, with `out_req` set to the requester, and makes no memory access. The requester becomes the owner at once, so a later get from a third core is forwarded to it.
- R4: A writeback (`req_kind` 1) from the owner writes its data to memory. Once the write completes, an acknowledgement (`out_kind` 2) goes to that core, and the block becomes unowned, so the next get reads the written value.
- R5: A writeback from a core that is not the owner gets a negative acknowledgement (`out_kind` 3), and memory is not written.
- R6: A DMA read (`req_kind` 2) or write (`req_kind` 3) to an unowned block goes straight to memory. Its result is a DMA data message (`out_kind` 5) carrying the read value, or a DMA done message (`out_kind` 6). Both carry `out_dst` 0.
- R7: A DMA access to an owned block first sends an invalidation (`out_kind` 4) to the owner. When the owner's writeback arrives, that core is acknowledged and memory is written: with the writeback data for a DMA read, with the DMA data for a DMA write. The DMA result is then returned, with the writeback data for a read, and the block is left unowned.
- R8: A request to a block in a transient state is kept in the queue and served in arrival order once the block is stable. `req_ready` is low only while the queue holds QDEPTH entries.
- R9: At most one memory request is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room; request taken when both high |
| req_kind | input | 2 | 0 get, 1 writeback, 2 DMA read, 3 DMA write |
| req_src | input | CORE_W | Requesting core (ignored for DMA) |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Writeback or DMA write data |
| mem_req_valid | output | 1 | One-cycle memory request strobe |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_blk | output | BLK_W | Memory block index |
| mem_req_data | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | One-cycle memory completion (read data or write done) |
| mem_rsp_data | input | DATA_W | Memory read data |
| out_valid | output | 1 | Message strobe |
| out_kind | output | 3 | Message code per R2 to R7 |
| out_dst | output | CORE_W | Destination core |
| out_req | output | CORE_W | New owner carried by a forward, else 0 |
| out_blk | output | BLK_W | Block of the message |
| out_data | output | DATA_W | Payload of data messages, else 0 |

## Verification
A wrong owner record appears at the ports the next time the block is requested. The forward or invalidation goes to the wrong core, or a valid writeback is refused, within two cycles of that request. A block stuck in a transient state never serves its queued requests, and `req_ready` eventually stays low. Stale memory contents show up as a wrong payload in the next data or DMA read message for that block. The bench therefore chains accesses to one block through every path and reads each result back through the ports.

// File: rtl/mi_dir_pkg.sv
package mi_dir_pkg;

    typedef enum logic [1:0] {
        RQ_EXCL   = 2'd0,
        RQ_WBACK  = 2'd1,
        RQ_DMA_RD = 2'd2,
        RQ_DMA_WR = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        MS_FWD      = 3'd0,
        MS_DATA     = 3'd1,
        MS_ACK      = 3'd2,
        MS_NACK     = 3'd3,
        MS_INV      = 3'd4,
        MS_DMA_DATA = 3'd5,
        MS_DMA_DONE = 3'd6
    } msg_kind_e;

    typedef enum logic [2:0] {
        BS_I       = 3'd0,
        BS_M       = 3'd1,
        BS_IM_MEM  = 3'd2,
        BS_MI_MEM  = 3'd3,
        BS_DMA_INV = 3'd4,
        BS_DMA_MEM = 3'd5
    } blk_state_e;

endpackage

// File: rtl/mi_dir_queue.sv
module mi_dir_queue #(
    parameter int DEPTH   = 4,
    parameter int ENTRY_W = 8,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [ENTRY_W-1:0]              push_ent,
    input  logic                            pop,
    input  logic [IDX_W-1:0]                pop_idx,
    output logic [DEPTH-1:0][ENTRY_W-1:0]   ent_o,
    output logic [DEPTH-1:0]                vld_o,
    output logic                            full_o
);

    typedef struct packed {
        logic [DEPTH-1:0]              vld;
        logic [DEPTH-1:0][ENTRY_W-1:0] ent;
    } q_t;

    q_t q_d, q_q;

    // Entries stay packed toward index 0, so index 0 is always the oldest.
    assign full_o = &q_q.vld;
    assign ent_o  = q_q.ent;
    assign vld_o  = q_q.vld;

    always_comb begin
        logic placed;
        q_d    = q_q;
        placed = 1'b0;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(pop_idx)) begin
                    q_d.ent[i] = q_q.ent[i+1];
                    q_d.vld[i] = q_q.vld[i+1];
                end
            end
            q_d.vld[DEPTH-1] = 1'b0;
            q_d.ent[DEPTH-1] = '0;
        end
        if (push && !full_o) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !q_d.vld[i]) begin
                    q_d.vld[i] = 1'b1;
                    q_d.ent[i] = push_ent;
                    placed     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

endmodule

// File: rtl/mi_dir_pick.sv
module mi_dir_pick #(
    parameter int N      = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Lowest index wins: that is the oldest queued request.
    always_comb begin
        found = |cand;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/mi_dir_ctrl.sv
module mi_dir_ctrl
    import mi_dir_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W     = 32,
    parameter int QDEPTH     = 4,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [CORE_W-1:0] req_src,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [BLK_W-1:0]  mem_req_blk,
    output logic [DATA_W-1:0] mem_req_data,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              out_valid,
    output logic [2:0]        out_kind,
    output logic [CORE_W-1:0] out_dst,
    output logic [CORE_W-1:0] out_req,
    output logic [BLK_W-1:0]  out_blk,
    output logic [DATA_W-1:0] out_data
);

    localparam int ENTRY_W = 2 + CORE_W + BLK_W + DATA_W;
    localparam int QI_W    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

    typedef struct packed {
        req_kind_e         kind;
        logic [CORE_W-1:0] src;
        logic [BLK_W-1:0]  blk;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef struct packed {
        blk_state_e [NUM_BLOCKS-1:0]        bst;
        logic [NUM_BLOCKS-1:0][CORE_W-1:0]  own;
        logic                               mem_busy;
        logic [BLK_W-1:0]                   mem_blk;
        logic                               dma_active;
        logic                               dma_write;
        logic                               dma_have;
        logic [DATA_W-1:0]                  dma_data;
        logic                               mreq_v;
        logic                               mreq_w;
        logic [BLK_W-1:0]                   mreq_blk;
        logic [DATA_W-1:0]                  mreq_data;
        logic                               ov;
        msg_kind_e                          okind;
        logic [CORE_W-1:0]                  odst;
        logic [CORE_W-1:0]                  oreq;
        logic [BLK_W-1:0]                   oblk;
        logic [DATA_W-1:0]                  odata;
    } ctl_t;

    ctl_t c_d, c_q;

    function automatic req_kind_e ent_kind(input entry_t e);
        return e.kind;
    endfunction

    function automatic logic [CORE_W-1:0] ent_src(input entry_t e);
        return e.src;
    endfunction

    function automatic logic [BLK_W-1:0] ent_blk(input entry_t e);
        return e.blk;
    endfunction

    // ---------------------------------------------------------------
    // Request queue and oldest-eligible selection
    // ---------------------------------------------------------------
    logic [QDEPTH-1:0][ENTRY_W-1:0] q_ent;
    logic [QDEPTH-1:0]              q_vld;
    logic                           q_full;
    logic [QDEPTH-1:0]              elig;
    logic                           pick_found;
    logic [QI_W-1:0]                pick_idx;
    logic                           pop;
    entry_t                         in_ent;

    assign in_ent.kind = req_kind_e'(req_kind);
    assign in_ent.src  = req_src;
    assign in_ent.blk  = req_blk;
    assign in_ent.data = req_data;
    assign req_ready   = !q_full;

    mi_dir_queue #(.DEPTH(QDEPTH), .ENTRY_W(ENTRY_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (req_valid),
        .push_ent (in_ent),
        .pop      (pop),
        .pop_idx  (pick_idx),
        .ent_o    (q_ent),
        .vld_o    (q_vld),
        .full_o   (q_full)
    );

    for (genvar g = 0; g < QDEPTH; g++) begin : g_elig
        req_kind_e         k_g;
        logic [CORE_W-1:0] s_g;
        logic [BLK_W-1:0]  b_g;
        blk_state_e        st_g;
        logic              own_hit_g;
        logic              ok_g;

        assign k_g = ent_kind(entry_t'(q_ent[g]));
        assign s_g = ent_src(entry_t'(q_ent[g]));
        assign b_g = ent_blk(entry_t'(q_ent[g]));

        always_comb begin
            st_g      = c_q.bst[b_g];
            own_hit_g = (c_q.own[b_g] == s_g);
            case (k_g)
                RQ_EXCL:  ok_g = (st_g == BS_M) || (st_g == BS_I && !c_q.mem_busy);
                RQ_WBACK: ok_g = (st_g == BS_I)
                              || (st_g == BS_M && (!own_hit_g || !c_q.mem_busy))
                              || (st_g == BS_DMA_INV && own_hit_g && !c_q.mem_busy);
                default:  ok_g = !c_q.dma_active
                              && ((st_g == BS_M) || (st_g == BS_I && !c_q.mem_busy));
            endcase
            elig[g] = q_vld[g] && ok_g;
        end
    end

    mi_dir_pick #(.N(QDEPTH)) u_pick (
        .cand  (elig),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        entry_t            sel;
        logic [BLK_W-1:0]  b;
        blk_state_e        cur;
        logic [CORE_W-1:0] own;

        c_d           = c_q;
        c_d.ov        = 1'b0;
        c_d.okind     = MS_FWD;
        c_d.odst      = '0;
        c_d.oreq      = '0;
        c_d.oblk      = '0;
        c_d.odata     = '0;
        c_d.mreq_v    = 1'b0;
        c_d.mreq_w    = 1'b0;
        c_d.mreq_blk  = '0;
        c_d.mreq_data = '0;
        pop           = 1'b0;
        sel           = entry_t'(q_ent[pick_idx]);
        b             = '0;
        cur           = BS_I;
        own           = '0;

        if (mem_rsp_valid && c_q.mem_busy) begin
            // Memory completion has the message slot this cycle.
            b            = c_q.mem_blk;
            c_d.mem_busy = 1'b0;
            c_d.ov       = 1'b1;
            c_d.oblk     = b;
            case (c_q.bst[b])
                BS_IM_MEM: begin
                    c_d.okind  = MS_DATA;
                    c_d.odst   = c_q.own[b];
                    c_d.odata  = mem_rsp_data;
                    c_d.bst[b] = BS_M;
                end
                BS_MI_MEM: begin
                    c_d.okind  = MS_ACK;
                    c_d.odst   = c_q.own[b];
                    c_d.bst[b] = BS_I;
                end
                BS_DMA_MEM: begin
                    c_d.okind      = c_q.dma_write ? MS_DMA_DONE : MS_DMA_DATA;
                    c_d.odata      = c_q.dma_write ? '0
                                   : (c_q.dma_have ? c_q.dma_data : mem_rsp_data);
                    c_d.bst[b]     = BS_I;
                    c_d.dma_active = 1'b0;
                    c_d.dma_have   = 1'b0;
                end
                default: c_d.ov = 1'b0;
            endcase
        end else if (pick_found) begin
            pop      = 1'b1;
            b        = sel.blk;
            cur      = c_q.bst[b];
            own      = c_q.own[b];
            c_d.oblk = b;
            case (sel.kind)
                RQ_EXCL: begin
                    if (cur == BS_M) begin
                        c_d.ov     = 1'b1;
                        c_d.okind  = MS_FWD;
                        c_d.odst   = own;
                        c_d.oreq   = sel.src;
                    end else begin
                        c_d.mreq_v   = 1'b1;
                        c_d.mreq_blk = b;
                        c_d.mem_busy = 1'b1;
                        c_d.mem_blk  = b;
                        c_d.bst[b]   = BS_IM_MEM;
                    end
                    c_d.own[b] = sel.src;
                end
                RQ_WBACK: begin
                    if (cur == BS_M && own == sel.src) begin
                        c_d.mreq_v    = 1'b1;
                        c_d.mreq_w    = 1'b1;
                        c_d.mreq_blk  = b;
                        c_d.mreq_data = sel.data;
                        c_d.mem_busy  = 1'b1;
                        c_d.mem_blk   = b;
                        c_d.bst[b]    = BS_MI_MEM;
                    end else if (cur == BS_DMA_INV) begin
                        c_d.ov        = 1'b1;
                        c_d.okind     = MS_ACK;
                        c_d.odst      = sel.src;
                        c_d.mreq_v    = 1'b1;
                        c_d.mreq_w    = 1'b1;
                        c_d.mreq_blk  = b;
                        c_d.mreq_data = c_q.dma_write ? c_q.dma_data : sel.data;
                        c_d.mem_busy  = 1'b1;
                        c_d.mem_blk   = b;
                        c_d.bst[b]    = BS_DMA_MEM;
                        if (!c_q.dma_write) begin
                            c_d.dma_data = sel.data;
                            c_d.dma_have = 1'b1;
                        end
                    end else begin
                        c_d.ov    = 1'b1;
                        c_d.okind = MS_NACK;
                        c_d.odst  = sel.src;
                    end
                end
                default: begin
                    c_d.dma_active = 1'b1;
                    c_d.dma_write  = (sel.kind == RQ_DMA_WR);
                    c_d.dma_data   = sel.data;
                    c_d.dma_have   = 1'b0;
                    if (cur == BS_M) begin
                        c_d.ov     = 1'b1;
                        c_d.okind  = MS_INV;
                        c_d.odst   = own;
                        c_d.bst[b] = BS_DMA_INV;
                    end else begin
                        c_d.mreq_v    = 1'b1;
                        c_d.mreq_w    = (sel.kind == RQ_DMA_WR);
                        c_d.mreq_blk  = b;
                        c_d.mreq_data = sel.data;
                        c_d.mem_busy  = 1'b1;
                        c_d.mem_blk   = b;
                        c_d.bst[b]    = BS_DMA_MEM;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign mem_req_valid = c_q.mreq_v;
    assign mem_req_write = c_q.mreq_w;
    assign mem_req_blk   = c_q.mreq_blk;
    assign mem_req_data  = c_q.mreq_data;
    assign out_valid     = c_q.ov;
    assign out_kind      = c_q.okind;
    assign out_dst       = c_q.odst;
    assign out_req       = c_q.oreq;
    assign out_blk       = c_q.oblk;
    assign out_data      = c_q.odata;

endmodule

// File: rtl/mi_dir_ctrl_chk.sv
module mi_dir_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_req_valid,
    input logic       mem_rsp_valid,
    input logic       out_valid,
    input logic [2:0] out_kind
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pend_q <= 1'b0;
        else if (mem_req_valid) pend_q <= 1'b1;
        else if (mem_rsp_valid) pend_q <= 1'b0;
    end

    AST_SINGLE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !pend_q); // R9

    AST_DATA_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd1) |-> $past(mem_rsp_valid)); // R2

    AST_FWD_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd0) |-> !mem_req_valid); // R3

    AST_NACK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd3) |-> !mem_req_valid); // R5

    AST_DMA_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == 3'd5 || out_kind == 3'd6)) |-> $past(mem_rsp_valid)); // R6

endmodule

bind mi_dir_ctrl mi_dir_ctrl_chk u_chk (.*);

// File: tb/mi_dir_ctrl_tb.sv
module mi_dir_ctrl_tb;

    localparam int NC = 4;
    localparam int NB = 8;
    localparam int DW = 32;
    localparam int QD = 4;
    localparam int CW = 2;
    localparam int BW = 3;

    localparam int K_GET = 0, K_WB = 1, K_DRD = 2, K_DWR = 3;
    localparam int M_FWD = 0, M_DATA = 1, M_ACK = 2, M_NACK = 3, M_INV = 4,
                   M_DDATA = 5, M_DDONE = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_kind;
    logic [CW-1:0] req_src;
    logic [BW-1:0] req_blk;
    logic [DW-1:0] req_data;
    logic          mem_req_valid;
    logic          mem_req_write;
    logic [BW-1:0] mem_req_blk;
    logic [DW-1:0] mem_req_data;
    logic          mem_rsp_valid;
    logic [DW-1:0] mem_rsp_data;
    logic          out_valid;
    logic [2:0]    out_kind;
    logic [CW-1:0] out_dst;
    logic [CW-1:0] out_req;
    logic [BW-1:0] out_blk;
    logic [DW-1:0] out_data;

    always #4 clk = ~clk;

    mi_dir_ctrl #(.NUM_CORES(NC), .NUM_BLOCKS(NB), .DATA_W(DW), .QDEPTH(QD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_blk(mem_req_blk), .mem_req_data(mem_req_data),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst),
        .out_req(out_req), .out_blk(out_blk), .out_data(out_data)
    );

    typedef struct {
        int          k;
        int          dst;
        int          rq;
        int          blk;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    int          checks = 0;
    int          fails = 0;
    int          mem_lat = 3;
    int          mem_reads = 0;
    int          mem_writes = 0;
    logic [31:0] mem_arr [NB];

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_msg(input int k, input int dst, input int rq, input int blk,
                              input logic [31:0] data, input string tag);
        exp_t e;
        e.k = k; e.dst = dst; e.rq = rq; e.blk = blk; e.data = data; e.tag = tag;
        expq.push_back(e);
    endtask

    // Driver: called at a falling edge, returns at a falling edge.
    task automatic send(input int kind, input int src, input int blk, input logic [31:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_src   = CW'(src);
        req_blk   = BW'(blk);
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        exp_t e;
        for (int i = 0; i < 400 && expq.size() != 0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        while (expq.size() != 0) begin
            e = expq.pop_front();
            checks++;
            fails++;
            $display("FAIL %s missing message: actual none expected kind %0d dst %0d",
                     e.tag, e.k, e.dst);
        end
    endtask

    // Memory model with one-cycle response strobe.
    initial begin
        int          cnt;
        bit          pend;
        logic [31:0] rdata;
        cnt = 0; pend = 1'b0; rdata = '0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rdata;
                    pend          = 1'b0;
                end else begin
                    cnt--;
                end
            end
            if (rst_n && mem_req_valid) begin
                chk("R9", "memory request while one outstanding", 32'(pend), 32'd0);
                pend = 1'b1;
                cnt  = mem_lat - 1;
                if (mem_req_write) begin
                    mem_arr[mem_req_blk] = mem_req_data;
                    mem_writes++;
                end else begin
                    rdata = mem_arr[mem_req_blk];
                    mem_reads++;
                end
            end
        end
    end

    // Monitor: scoreboard of outgoing messages.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                checks++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL unexpected message: actual kind %0d dst %0d blk %0d expected none",
                             out_kind, out_dst, out_blk);
                end else begin
                    e = expq.pop_front();
                    if (int'(out_kind) != e.k || int'(out_dst) != e.dst || int'(out_req) != e.rq ||
                        int'(out_blk) != e.blk || out_data !== e.data) begin
                        fails++;
                        $display("FAIL %s message: actual k%0d d%0d r%0d b%0d %0h expected k%0d d%0d r%0d b%0d %0h",
                                 e.tag, out_kind, out_dst, out_req, out_blk, out_data,
                                 e.k, e.dst, e.rq, e.blk, e.data);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int ops0;
        int w0;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_kind  = '0;
        req_src   = '0;
        req_blk   = '0;
        req_data  = '0;
        for (int b = 0; b < NB; b++) mem_arr[b] = 32'hA000_0000 + 32'(b);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);
        chk("R1", "req_ready", 32'(req_ready), 32'd1);

        // R2 get to unowned block
        expect_msg(M_DATA, 1, 0, 2, 32'hA000_0002, "R2");
        send(K_GET, 1, 2, 0);
        wait_done();
        chk("R2", "memory reads", 32'(mem_reads), 32'd1);

        // R3 forwards, ownership moves at once
        ops0 = mem_reads + mem_writes;
        expect_msg(M_FWD, 1, 3, 2, 0, "R3");
        send(K_GET, 3, 2, 0);
        wait_done();
        expect_msg(M_FWD, 3, 0, 2, 0, "R3");
        send(K_GET, 0, 2, 0);
        wait_done();
        chk("R3", "memory accesses on forward", 32'(mem_reads + mem_writes), 32'(ops0));

        // R5 stale writeback refused
        w0 = mem_writes;
        expect_msg(M_NACK, 3, 0, 2, 0, "R5");
        send(K_WB, 3, 2, 32'hDEAD_0000);
        wait_done();
        chk("R5", "memory writes after NACK", 32'(mem_writes), 32'(w0));

        // R4 owner writeback, then get reads written value
        expect_msg(M_ACK, 0, 0, 2, 0, "R4");
        send(K_WB, 0, 2, 32'h1111_2222);
        wait_done();
        chk("R4", "memory writes after writeback", 32'(mem_writes), 32'(w0 + 1));
        expect_msg(M_DATA, 2, 0, 2, 32'h1111_2222, "R4");
        send(K_GET, 2, 2, 0);
        wait_done();

        // R6 DMA to unowned block
        expect_msg(M_DDATA, 0, 0, 5, 32'hA000_0005, "R6");
        send(K_DRD, 0, 5, 0);
        wait_done();
        expect_msg(M_DDONE, 0, 0, 5, 0, "R6");
        send(K_DWR, 0, 5, 32'h0000_5555);
        wait_done();
        expect_msg(M_DDATA, 0, 0, 5, 32'h0000_5555, "R6");
        send(K_DRD, 0, 5, 0);
        wait_done();

        // R7 DMA read of owned block, with a stalled get behind it (R8)
        expect_msg(M_INV, 2, 0, 2, 0, "R7");
        expect_msg(M_ACK, 2, 0, 2, 0, "R7");
        expect_msg(M_DDATA, 0, 0, 2, 32'h0000_7777, "R7");
        expect_msg(M_DATA, 1, 0, 2, 32'h0000_7777, "R8");
        send(K_DRD, 0, 2, 0);
        send(K_GET, 1, 2, 0);
        send(K_WB, 2, 2, 32'h0000_7777);
        wait_done();

        // R7 DMA write of owned block: DMA data wins
        expect_msg(M_INV, 1, 0, 2, 0, "R7");
        expect_msg(M_ACK, 1, 0, 2, 0, "R7");
        expect_msg(M_DDONE, 0, 0, 2, 0, "R7");
        send(K_DWR, 0, 2, 32'h0000_9999);
        send(K_WB, 1, 2, 32'h0000_1234);
        wait_done();
        expect_msg(M_DDATA, 0, 0, 2, 32'h0000_9999, "R7");
        send(K_DRD, 0, 2, 0);
        wait_done();
        expect_msg(M_DATA, 3, 0, 2, 32'h0000_9999, "R7");
        send(K_GET, 3, 2, 0);
        wait_done();

        // R8 queue fills behind a slow memory read, order preserved
        mem_lat = 20;
        expect_msg(M_DATA, 0, 0, 6, 32'hA000_0006, "R8");
        expect_msg(M_FWD, 0, 1, 6, 0, "R8");
        expect_msg(M_FWD, 1, 2, 6, 0, "R8");
        expect_msg(M_FWD, 2, 3, 6, 0, "R8");
        expect_msg(M_FWD, 3, 0, 6, 0, "R8");
        send(K_GET, 0, 6, 0);
        send(K_GET, 1, 6, 0);
        send(K_GET, 2, 6, 0);
        send(K_GET, 3, 6, 0);
        send(K_GET, 0, 6, 0);
        chk("R8", "req_ready with full queue", 32'(req_ready), 32'd0);
        wait_done();
        chk("R8", "req_ready after drain", 32'(req_ready), 32'd1);
        mem_lat = 3;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule